// File: doc/BRIEF.md
# Physical Register Ready/Free Writeback Checker

This block keeps two status bits for every physical register of an out-of-order core: a ready bit that says a result has been written, and a free bit that says the register sits in the free list. Rename allocations clear both bits. A returning register sets its free bit. A result writeback sets the ready bit of its target.

Each writeback also acts as a consistency test. A correct target was allocated and has not yet been written, so both its bits read 0. If either bit is 1, the destination name is phantom, duplicated or stale, and the block raises a sticky fault flag that holds the tag of the first offending writeback. The register file data, wakeup logic and free-list storage are outside this block. It only watches the events that already flow through the pipeline.

Top module: `prf_wb_checker`

## Requirements
- R1: After reset, fault and fault_tag are 0. Tags 0 to NUM_ARCH-1 have ready=1 and free=0. Every other tag has ready=0 and free=1.
- R2: An allocation of a tag clears both its ready bit and its free bit. A single writeback to that tag afterwards raises no fault.
- R3: A writeback sets the ready bit of its target. A second writeback to the same tag with no allocation in between raises the fault.
- R4: A writeback to a tag whose free bit is 1 raises the fault. This covers a tag never allocated since reset and a tag that has been released.
- R5: A release sets the free bit of its tag.
- R6: When a release and an allocation name the same tag in one cycle, the release takes effect first and the allocation second. The tag ends allocated (free=0, ready=0).
- R7: In a cycle that carries both an allocation and a writeback, the writeback is checked against the bits as they stood before that cycle. For a shared tag, the ready bit ends at 1.
- R8: fault rises on the clock edge that ends the offending writeback cycle. At that edge fault_tag takes the tag of that writeback. Once set, fault and fault_tag hold until reset, whatever later writebacks occur.
- R9: A writeback to a tag that holds initial architectural state and has not been reallocated raises the fault, because its ready bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Rename allocates a physical register this cycle |
| alloc_tag | input | TAG_W | Tag being allocated |
| wb_vld | input | 1 | A result is written back this cycle |
| wb_tag | input | TAG_W | Destination tag of the writeback |
| rel_vld | input | 1 | A register returns to the free list this cycle |
| rel_tag | input | TAG_W | Tag being released |
| fault | output | 1 | Sticky consistency-fault flag |
| fault_tag | output | TAG_W | Tag of the first offending writeback |

## Verification
The assertions take the event inputs to be free of X and the tags to be below NUM_PREGS. The release assertion exempts the one case where an allocation of the same tag in the same cycle overrides the release. The stimulus drives only tags inside the table and holds all valids low during reset. It covers the overlap cases on purpose:
- a release and an allocation of one tag in the same cycle;
- an allocation and a writeback of one tag in the same cycle.

A random phase, with periodic resets, mixes legal and illegal event streams.

// File: rtl/prf_wb_checker.sv
module prf_wb_checker #(
  parameter int NUM_PREGS = 32,
  parameter int NUM_ARCH  = 8,
  localparam int TAG_W    = $clog2(NUM_PREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_vld,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             wb_vld,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             rel_vld,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             fault,
  output logic [TAG_W-1:0] fault_tag
);

  localparam logic [NUM_PREGS-1:0] ONE       = {{(NUM_PREGS-1){1'b0}}, 1'b1};
  localparam logic [NUM_PREGS-1:0] ARCH_MASK = {{(NUM_PREGS-NUM_ARCH){1'b0}}, {NUM_ARCH{1'b1}}};

  logic [NUM_PREGS-1:0] ready_q, free_q;
  logic [NUM_PREGS-1:0] alloc_dec, wb_dec, rel_dec;

  assign alloc_dec = alloc_vld ? (ONE << alloc_tag) : '0;
  assign wb_dec    = wb_vld    ? (ONE << wb_tag)    : '0;
  assign rel_dec   = rel_vld   ? (ONE << rel_tag)   : '0;

  wire wb_bad = wb_vld & (ready_q[wb_tag] | free_q[wb_tag]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= ARCH_MASK;
      free_q    <= ~ARCH_MASK;
      fault     <= 1'b0;
      fault_tag <= '0;
    end else begin
      free_q  <= (free_q | rel_dec) & ~alloc_dec;
      ready_q <= (ready_q & ~alloc_dec) | wb_dec;
      if (wb_bad && !fault) begin
        fault     <= 1'b1;
        fault_tag <= wb_tag;
      end
    end
  end

endmodule

module prf_wb_checker_sva #(
  parameter int NUM_PREGS = 32,
  localparam int TAG_W    = $clog2(NUM_PREGS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_vld,
  input logic [TAG_W-1:0]     alloc_tag,
  input logic                 wb_vld,
  input logic [TAG_W-1:0]     wb_tag,
  input logic                 rel_vld,
  input logic [TAG_W-1:0]     rel_tag,
  input logic [NUM_PREGS-1:0] ready_q,
  input logic [NUM_PREGS-1:0] free_q,
  input logic                 fault,
  input logic [TAG_W-1:0]     fault_tag
);

  a_r2_alloc_clears_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |=> !free_q[$past(alloc_tag)]);

  a_r3_wb_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |=> ready_q[$past(wb_tag)]);

  a_r5_release_sets_free: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && !(alloc_vld && alloc_tag == rel_tag)) |=> free_q[$past(rel_tag)]);

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  a_r8_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> $stable(fault_tag));

  a_r8_rise_from_wb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(wb_vld) && fault_tag == $past(wb_tag)));

endmodule

bind prf_wb_checker prf_wb_checker_sva #(.NUM_PREGS(NUM_PREGS)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
  .wb_vld(wb_vld), .wb_tag(wb_tag),
  .rel_vld(rel_vld), .rel_tag(rel_tag),
  .ready_q(ready_q), .free_q(free_q),
  .fault(fault), .fault_tag(fault_tag)
);

// File: tb/tb_prf_wb_checker.sv
module tb_prf_wb_checker;
  localparam int NP = 32;
  localparam int NA = 8;
  localparam int TW = $clog2(NP);

  logic clk = 0, rst_n = 0;
  logic alloc_vld = 0, wb_vld = 0, rel_vld = 0;
  logic [TW-1:0] alloc_tag = 0, wb_tag = 0, rel_tag = 0;
  logic fault;
  logic [TW-1:0] fault_tag;

  int errors = 0, checks = 0;
  bit m_ready[NP];
  bit m_free[NP];
  bit m_fault;
  int m_tag;

  always #10 clk = ~clk;

  prf_wb_checker #(.NUM_PREGS(NP), .NUM_ARCH(NA)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
    .wb_vld(wb_vld), .wb_tag(wb_tag),
    .rel_vld(rel_vld), .rel_tag(rel_tag),
    .fault(fault), .fault_tag(fault_tag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_ready[i] = (i < NA);
      m_free[i]  = (i >= NA);
    end
    m_fault = 0;
    m_tag   = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; alloc_vld = 0; wb_vld = 0; rel_vld = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    chk("R1 fault after reset", int'(fault), 0);
    chk("R1 fault_tag after reset", int'(fault_tag), 0);
  endtask

  task automatic step(string req, bit a, int at, bit w, int wt, bit r, int rt);
    bit bad;
    @(negedge clk);
    alloc_vld = a; alloc_tag = TW'(at);
    wb_vld = w;    wb_tag = TW'(wt);
    rel_vld = r;   rel_tag = TW'(rt);
    bad = w && (m_ready[wt] || m_free[wt]);
    @(posedge clk);
    if (r) m_free[rt] = 1;
    if (a) begin m_free[at] = 0; m_ready[at] = 0; end
    if (w) m_ready[wt] = 1;
    if (bad && !m_fault) begin m_fault = 1; m_tag = wt; end
    #1;
    chk({req, " fault"}, int'(fault), int'(m_fault));
    chk({req, " fault_tag"}, int'(fault_tag), m_tag);
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    step("R9 wb to arch reg", 0, 0, 1, 3, 0, 0);
    chk("R9 fault raised", int'(fault), 1);
    chk("R9 tag", int'(fault_tag), 3);

    do_reset();
    step("R4 wb to never-allocated", 0, 0, 1, 20, 0, 0);
    chk("R4 fault raised", int'(fault), 1);

    do_reset();
    step("R2 alloc", 1, 20, 0, 0, 0, 0);
    step("R2 first wb", 0, 0, 1, 20, 0, 0);
    chk("R2 no fault after alloc+wb", int'(fault), 0);
    step("R3 second wb", 0, 0, 1, 20, 0, 0);
    chk("R3 duplicate wb faults", int'(fault), 1);

    do_reset();
    step("R5 alloc", 1, 21, 0, 0, 0, 0);
    step("R5 wb", 0, 0, 1, 21, 0, 0);
    step("R5 release", 0, 0, 0, 0, 1, 21);
    step("R5 wb after release", 0, 0, 1, 21, 0, 0);
    chk("R5 released tag faults", int'(fault), 1);

    do_reset();
    step("R6 alloc", 1, 22, 0, 0, 0, 0);
    step("R6 wb", 0, 0, 1, 22, 0, 0);
    step("R6 rel+alloc same tag", 1, 22, 0, 0, 1, 22);
    step("R6 wb after realloc", 0, 0, 1, 22, 0, 0);
    chk("R6 tag ends allocated", int'(fault), 0);

    do_reset();
    step("R7 alloc+wb free tag", 1, 23, 1, 23, 0, 0);
    chk("R7 checked against prior state", int'(fault), 1);

    do_reset();
    step("R7 alloc", 1, 25, 0, 0, 0, 0);
    step("R7 realloc+wb", 1, 25, 1, 25, 0, 0);
    chk("R7 no fault on prior state", int'(fault), 0);
    step("R7 wb again", 0, 0, 1, 25, 0, 0);
    chk("R7 ready ended 1", int'(fault), 1);

    do_reset();
    @(negedge clk);
    wb_vld = 1; wb_tag = TW'(30);
    #5;
    chk("R8 no fault before edge", int'(fault), 0);
    step("R8 first offender", 0, 0, 1, 30, 0, 0);
    step("R8 second offender", 0, 0, 1, 31, 0, 0);
    chk("R8 tag held", int'(fault_tag), 30);
    for (int i = 0; i < 4; i++) idle("R8 idle");
    chk("R8 still set", int'(fault), 1);

    for (int k = 0; k < 20; k++) begin
      do_reset();
      for (int i = 0; i < 25; i++)
        step("R3 R4 R5 random", $urandom_range(0, 1) == 1, $urandom_range(0, NP-1),
             $urandom_range(0, 3) == 0, $urandom_range(0, NP-1),
             $urandom_range(0, 2) == 0, $urandom_range(0, NP-1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule